// File: doc/BRIEF.md
# Memory Reference Instruction Sequencer

This block carries out the memory-reference class of a 16-bit word-addressed processor: jump, jump to subroutine, increment-and-skip-if-zero, decrement-and-skip-if-zero, load accumulator and store accumulator. It owns the program counter and the four accumulators. When `start` is pulsed while the block is idle, it captures the instruction word and decodes it. It then forms an effective address from an 8-bit displacement and one of four base modes, and optionally follows one level of indirection. Finally it performs the operation through a simple request/acknowledge memory port.

Every memory access holds its request until the memory acknowledges, so any memory latency is accepted. Completion is shown by a one-cycle `done` pulse. Augmented and arithmetic encodings are not executed: they finish at once with `illegal` raised alongside `done`. The accumulators start at zero after reset, and a program fills them with load instructions.

Top module: `mrs_seq`

## Requirements
- R1: The instruction word decodes as follows. instr[15] must be 0, and instr[14:13] picks the class: 00 jump group, 01 load, 10 store. instr[12:11] picks the jump-group operation (0 jump, 1 jump to subroutine, 2 increment-and-skip, 3 decrement-and-skip) or, for load and store, the accumulator number. instr[10] is the indirect flag, instr[9:8] is the base mode and instr[7:0] is the displacement.
- R2: An instruction with instr[15]=1 or instr[14:13]=11 completes with `illegal` and `done` high in the same cycle. It makes no memory access and changes neither the PC nor any accumulator.
- R3: Base mode 0 gives the displacement zero-extended as the address. Modes 1, 2 and 3 add the sign-extended displacement to the current PC, AC2 or AC3 respectively, modulo 2^16.
- R4: With the indirect flag set, the word read at the computed address becomes the effective address. Exactly one extra read is made, with no further indirection.
- R5: Jump loads the PC with the effective address and makes no access beyond any indirect read.
- R6: Jump to subroutine writes the old PC plus one into AC3 and loads the PC with the effective address. The address is computed from the AC3 value held before the write.
- R7: Load writes the word read at the effective address into the named accumulator. Store writes the named accumulator to the effective address. Both advance the PC by one.
- R8: Increment-and-skip and decrement-and-skip read the word and write back the word plus or minus one, modulo 2^16. The PC then advances by two when the written value is zero and by one otherwise.
- R9: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack` is seen. An access completes on the cycle `mem_ack` is high.
- R10: `done` is high for exactly one cycle per accepted instruction, and `busy` is low on the cycle after `done`. A `start` raised while `busy` is high is ignored.
- R11: After reset the PC and all accumulators are zero, and `done`, `illegal`, `busy` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin executing `instr`; only sampled while idle |
| instr | input | 16 | Instruction word |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Valid with `done`: the instruction was rejected |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access accepted/completed |
| pc | output | 16 | Program counter |
| ac0 | output | 16 | Accumulator 0 |
| ac1 | output | 16 | Accumulator 1 |
| ac2 | output | 16 | Accumulator 2 |
| ac3 | output | 16 | Accumulator 3 |

## Verification
A wrong base selection or sign extension shows up in the memory address of the first request, one cycle after decode. A lost indirection or a wrong operation decode shows up as a changed count of accesses before `done`. A wrong skip or return-address value is visible on `pc` or `ac3` as soon as `done` rises. Any error in the handshake state makes the request drop or move before the acknowledge, or leaves `done` absent, and the bench's per-instruction timeout reports that within a few hundred cycles.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  localparam int WORD_W = 16;
  localparam int DISP_W = 8;
  localparam int NUM_AC = 4;
  localparam int AC_SEL_W = $clog2(NUM_AC);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_IND,
    ST_EXE,
    ST_RD,
    ST_WR,
    ST_FIN
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_JMP,
    OP_JSR,
    OP_ISZ,
    OP_DSZ,
    OP_LDA,
    OP_STA,
    OP_BAD
  } mref_op_e;

  typedef struct packed {
    mref_op_e            op;
    logic [AC_SEL_W-1:0] acn;
    logic                ind;
    logic [1:0]          mode;
    logic [DISP_W-1:0]   disp;
  } mref_dec_t;

endpackage

// File: rtl/mrs_decode.sv
module mrs_decode
  import mrs_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output mref_dec_t         dec
);

  localparam int ARITH_BIT = WORD_W - 1;
  localparam int CLS_LO    = WORD_W - 3;
  localparam int SUB_LO    = WORD_W - 5;
  localparam int IND_BIT   = WORD_W - 6;
  localparam int MODE_LO   = DISP_W;

  logic [1:0] cls;
  logic [1:0] sub;

  always_comb begin
    cls = instr[CLS_LO +: 2];
    sub = instr[SUB_LO +: 2];
    dec.acn  = sub;
    dec.ind  = instr[IND_BIT];
    dec.mode = instr[MODE_LO +: 2];
    dec.disp = instr[DISP_W-1:0];
    if (instr[ARITH_BIT]) begin
      dec.op = OP_BAD;
    end else begin
      unique case (cls)
        2'b00: begin
          unique case (sub)
            2'b00: dec.op = OP_JMP;
            2'b01: dec.op = OP_JSR;
            2'b10: dec.op = OP_ISZ;
            default: dec.op = OP_DSZ;
          endcase
        end
        2'b01:   dec.op = OP_LDA;
        2'b10:   dec.op = OP_STA;
        default: dec.op = OP_BAD;
      endcase
    end
  end

endmodule

// File: rtl/mrs_ea.sv
module mrs_ea #(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic [1:0]    mode,
  input  logic [DW-1:0] disp,
  input  logic [W-1:0]  pc,
  input  logic [W-1:0]  ac2,
  input  logic [W-1:0]  ac3,
  output logic [W-1:0]  ea
);

  localparam int EXT_W = W - DW;

  logic [W-1:0] disp_z;
  logic [W-1:0] disp_s;
  logic [W-1:0] base;

  always_comb begin
    disp_z = {{EXT_W{1'b0}}, disp};
    disp_s = {{EXT_W{disp[DW-1]}}, disp};
    unique case (mode)
      2'd1:    base = pc;
      2'd2:    base = ac2;
      2'd3:    base = ac3;
      default: base = '0;
    endcase
    ea = (mode == 2'd0) ? disp_z : (base + disp_s);
  end

endmodule

// File: rtl/mrs_regs.sv
module mrs_regs #(
  parameter int W   = 16,
  parameter int NAC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pc_we,
  input  logic [W-1:0]           pc_d,
  input  logic                   ac_we,
  input  logic [$clog2(NAC)-1:0] ac_sel,
  input  logic [W-1:0]           ac_d,
  output logic [W-1:0]           pc_q,
  output logic [NAC-1:0][W-1:0]  ac_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_we) begin
      pc_q <= pc_d;
    end
  end

  for (genvar g = 0; g < NAC; g++) begin : g_ac
    logic en;
    assign en = ac_we && (ac_sel == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ac_q[g] <= '0;
      end else if (en) begin
        ac_q[g] <= ac_d;
      end
    end

    a_r7_ac_write_only_when_selected: assert property (
      @(posedge clk) disable iff (!rst_n)
      (ac_q[g] != $past(ac_q[g])) |-> ($past(ac_we) && ($past(ac_sel) == g)));
  end

endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
  import mrs_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int DW = DISP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] instr,
  output logic         busy,
  output logic         done,
  output logic         illegal,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ack,
  output logic [W-1:0] pc,
  output logic [W-1:0] ac0,
  output logic [W-1:0] ac1,
  output logic [W-1:0] ac2,
  output logic [W-1:0] ac3
);

  localparam int AC_RET = NUM_AC - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe[1];

  seq_state_e state_q, state_d;
  logic [W-1:0] ir_q, ir_d;
  logic [W-1:0] ea_q, ea_d;
  logic [W-1:0] data_q, data_d;
  logic         ill_q, ill_d;

  mref_dec_t           dec;
  logic [W-1:0]        ea_calc;
  logic                pc_we;
  logic [W-1:0]        pc_d;
  logic                ac_we;
  logic [AC_SEL_W-1:0] ac_sel;
  logic [W-1:0]        ac_d;
  logic [W-1:0]        pc_q;
  logic [NUM_AC-1:0][W-1:0] ac_q;

  mrs_decode u_dec (
    .instr (ir_q),
    .dec   (dec)
  );

  mrs_ea #(.W(W), .DW(DW)) u_ea (
    .mode (dec.mode),
    .disp (dec.disp),
    .pc   (pc_q),
    .ac2  (ac_q[2]),
    .ac3  (ac_q[3]),
    .ea   (ea_calc)
  );

  mrs_regs #(.W(W), .NAC(NUM_AC)) u_regs (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .pc_we  (pc_we),
    .pc_d   (pc_d),
    .ac_we  (ac_we),
    .ac_sel (ac_sel),
    .ac_d   (ac_d),
    .pc_q   (pc_q),
    .ac_q   (ac_q)
  );

  // next state
  always_comb begin
    state_d = state_q;
    ir_d    = ir_q;
    ea_d    = ea_q;
    data_d  = data_q;
    ill_d   = ill_q;
    pc_we   = 1'b0;
    pc_d    = pc_q + W'(1);
    ac_we   = 1'b0;
    ac_sel  = dec.acn;
    ac_d    = mem_rdata;

    unique case (state_q)
      ST_IDLE: begin
        ill_d = 1'b0;
        if (start) begin
          ir_d    = instr;
          state_d = ST_DEC;
        end
      end
      ST_DEC: begin
        ea_d = ea_calc;
        if (dec.op == OP_BAD) begin
          ill_d   = 1'b1;
          state_d = ST_FIN;
        end else if (dec.ind) begin
          state_d = ST_IND;
        end else begin
          state_d = ST_EXE;
        end
      end
      ST_IND: begin
        if (mem_ack) begin
          ea_d    = mem_rdata;
          state_d = ST_EXE;
        end
      end
      ST_EXE: begin
        unique case (dec.op)
          OP_JMP: begin
            pc_we   = 1'b1;
            pc_d    = ea_q;
            state_d = ST_FIN;
          end
          OP_JSR: begin
            ac_we   = 1'b1;
            ac_sel  = AC_SEL_W'(AC_RET);
            ac_d    = pc_q + W'(1);
            pc_we   = 1'b1;
            pc_d    = ea_q;
            state_d = ST_FIN;
          end
          OP_STA: begin
            data_d  = ac_q[dec.acn];
            state_d = ST_WR;
          end
          default: state_d = ST_RD;
        endcase
      end
      ST_RD: begin
        if (mem_ack) begin
          if (dec.op == OP_LDA) begin
            ac_we   = 1'b1;
            pc_we   = 1'b1;
            state_d = ST_FIN;
          end else begin
            data_d  = (dec.op == OP_ISZ) ? (mem_rdata + W'(1))
                                         : (mem_rdata - W'(1));
            state_d = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (mem_ack) begin
          pc_we = 1'b1;
          if (dec.op != OP_STA && data_q == '0) begin
            pc_d = pc_q + W'(2);
          end
          state_d = ST_FIN;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      ir_q    <= '0;
      ea_q    <= '0;
      data_q  <= '0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ill_q   <= ill_d;
      if (state_q == ST_IDLE) begin
        ir_q <= ir_d;
      end
      if (state_q == ST_DEC || state_q == ST_IND) begin
        ea_q <= ea_d;
      end
      if (state_q == ST_EXE || state_q == ST_RD) begin
        data_q <= data_d;
      end
    end
  end

  // outputs
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign illegal   = done && ill_q;
  assign mem_req   = (state_q == ST_IND) || (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = ea_q;
  assign mem_wdata = data_q;
  assign pc        = pc_q;
  assign ac0       = ac_q[0];
  assign ac1       = ac_q[1];
  assign ac2       = ac_q[2];
  assign ac3       = ac_q[3];

  // checks
  a_r9_req_held_until_ack: assert property (
    @(posedge clk) disable iff (!rst_s_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  a_r10_done_single_cycle: assert property (
    @(posedge clk) disable iff (!rst_s_n)
    done |=> !done);

  a_r10_idle_after_done: assert property (
    @(posedge clk) disable iff (!rst_s_n)
    done |=> !busy);

  a_r2_illegal_only_with_done: assert property (
    @(posedge clk) disable iff (!rst_s_n)
    illegal |-> done);

  a_r2_no_access_when_rejected: assert property (
    @(posedge clk) disable iff (!rst_s_n)
    ill_q |-> !mem_req);

  a_r5_pc_moves_only_at_completion: assert property (
    @(posedge clk) disable iff (!rst_s_n)
    (pc != $past(pc)) |-> done);

  a_r10_start_needs_idle: assert property (
    @(posedge clk) disable iff (!rst_s_n)
    (busy && !done) |=> busy);

endmodule

// File: tb/tb_mrs_seq.sv
module tb_mrs_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] instr;
  logic        busy, done, illegal;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack;
  logic [15:0] pc, ac0, ac1, ac2, ac3;

  always #10 clk = ~clk;

  mrs_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .busy(busy), .done(done), .illegal(illegal),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .pc(pc), .ac0(ac0), .ac1(ac1), .ac2(ac2), .ac3(ac3)
  );

  int checks = 0;
  int fails  = 0;
  int n_acc  = 0;

  logic [15:0] dmem [logic [15:0]];
  logic [15:0] rmem [logic [15:0]];
  logic [15:0] m_pc;
  logic [15:0] m_ac [4];

  function automatic logic [15:0] fillw(logic [15:0] a);
    return a ^ 16'h3c5a ^ {a[7:0], a[15:8]};
  endfunction

  function automatic logic [15:0] rd_dut(logic [15:0] a);
    return dmem.exists(a) ? dmem[a] : fillw(a);
  endfunction

  function automatic logic [15:0] rd_ref(logic [15:0] a);
    return rmem.exists(a) ? rmem[a] : fillw(a);
  endfunction

  function automatic logic [15:0] sext8(logic [7:0] d);
    return {{8{d[7]}}, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: variable latency, ack held one cycle
  int wait_left = 0;
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wait_left = int'($urandom % 3);
      end else if (mem_req) begin
        if (wait_left == 0) begin
          mem_ack   = 1'b1;
          mem_rdata = rd_dut(mem_addr);
          if (mem_we) dmem[mem_addr] = mem_wdata;
          n_acc++;
        end else begin
          wait_left--;
        end
      end
    end
  end

  // execute one instruction through the DUT and the bench model
  task automatic run(input logic [15:0] iw, input bit restart_busy);
    logic [1:0]  cls, sub, mode;
    logic        ind, bad, wr;
    logic [15:0] ea, base, v, wa;
    int          exp_acc, acc0, cnt;
    string       tag;
    cls  = iw[14:13];
    sub  = iw[12:11];
    ind  = iw[10];
    mode = iw[9:8];
    bad  = iw[15] || (cls == 2'b11);
    wr   = 1'b0;
    wa   = '0;
    exp_acc = 0;
    tag = "R7";
    if (!bad) begin
      // R3 effective address
      base = (mode == 2'd1) ? m_pc : (mode == 2'd2) ? m_ac[2] : m_ac[3];
      ea   = (mode == 2'd0) ? {8'h00, iw[7:0]} : base + sext8(iw[7:0]);
      if (ind) begin // R4 single indirection
        ea = rd_ref(ea);
        exp_acc++;
      end
      if (cls == 2'b00) begin
        case (sub)
          2'd0: begin m_pc = ea; tag = "R5"; end
          2'd1: begin m_ac[3] = m_pc + 16'd1; m_pc = ea; tag = "R6"; end
          default: begin // R8
            v = (sub == 2'd2) ? rd_ref(ea) + 16'd1 : rd_ref(ea) - 16'd1;
            rmem[ea] = v;
            wr = 1'b1; wa = ea;
            m_pc = m_pc + ((v == 16'd0) ? 16'd2 : 16'd1);
            exp_acc += 2;
            tag = "R8";
          end
        endcase
      end else if (cls == 2'b01) begin
        m_ac[sub] = rd_ref(ea);
        m_pc = m_pc + 16'd1;
        exp_acc++;
      end else begin
        rmem[ea] = m_ac[sub];
        wr = 1'b1; wa = ea;
        m_pc = m_pc + 16'd1;
        exp_acc++;
      end
    end else begin
      tag = "R2";
    end

    acc0 = n_acc;
    @(negedge clk);
    instr = iw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart_busy && !bad) begin
      @(negedge clk);
      chk(busy == 1'b1, "R10 busy during instruction", {15'd0, busy}, 16'd1);
      instr = ~iw;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cnt = 0;
    while (!done && cnt < 300) begin
      @(negedge clk);
      cnt++;
    end
    if (!done) begin
      chk(1'b0, "R9 done timeout", 16'd0, 16'd1);
      return;
    end
    chk(illegal == bad, {tag, " illegal flag"}, {15'd0, illegal}, {15'd0, bad});
    chk(pc == m_pc, {tag, " pc"}, pc, m_pc);
    chk(ac0 == m_ac[0] && ac1 == m_ac[1] && ac2 == m_ac[2], {tag, " ac0-2"},
        ac0 ^ ac1 ^ ac2, m_ac[0] ^ m_ac[1] ^ m_ac[2]);
    chk(ac3 == m_ac[3], {tag, " ac3"}, ac3, m_ac[3]);
    chk((n_acc - acc0) == exp_acc, {tag, " R4 R9 access count"},
        16'(n_acc - acc0), 16'(exp_acc));
    if (wr) chk(rd_dut(wa) == rd_ref(wa), {tag, " written word"}, rd_dut(wa), rd_ref(wa));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 single done pulse", {14'd0, done, busy}, 16'd0);
    if (restart_busy) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R10 start while busy ignored", {15'd0, busy}, 16'd0);
    end
  endtask

  // word builder: class, sub, ind, mode, disp
  function automatic logic [15:0] mk(logic [1:0] c, logic [1:0] s, logic i,
                                     logic [1:0] m, logic [7:0] d);
    return {1'b0, c, s, i, m, d};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start = 1'b0;
    instr = '0;
    m_pc  = '0;
    for (int k = 0; k < 4; k++) m_ac[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk(pc == 16'd0, "R11 pc", pc, 16'd0);
    chk({ac0, ac1, ac2, ac3} == 64'd0, "R11 accumulators", ac0 | ac1 | ac2 | ac3, 16'd0);
    chk(!done && !illegal && !busy && !mem_req, "R11 control outputs",
        {12'd0, done, illegal, busy, mem_req}, 16'd0);

    // directed corner cases (R1 field positions)
    dmem[16'h0010] = 16'h1234; rmem[16'h0010] = 16'h1234;
    run(mk(2'b01, 2'd2, 1'b0, 2'd0, 8'h10), 1'b0);   // R7 load AC2 page zero
    run(mk(2'b01, 2'd3, 1'b0, 2'd0, 8'hff), 1'b0);   // R3 page zero top
    run(mk(2'b10, 2'd2, 1'b0, 2'd2, 8'h80), 1'b0);   // R3 AC2 negative disp
    dmem[16'h0020] = 16'hffff; rmem[16'h0020] = 16'hffff;
    run(mk(2'b00, 2'd2, 1'b0, 2'd0, 8'h20), 1'b0);   // R8 ISZ wraps to zero: skip
    dmem[16'h0021] = 16'h0001; rmem[16'h0021] = 16'h0001;
    run(mk(2'b00, 2'd3, 1'b0, 2'd0, 8'h21), 1'b0);   // R8 DSZ to zero: skip
    run(mk(2'b00, 2'd3, 1'b0, 2'd0, 8'h21), 1'b0);   // R8 DSZ to ffff: no skip
    dmem[16'h0030] = 16'h0400; rmem[16'h0030] = 16'h0400;
    run(mk(2'b00, 2'd0, 1'b1, 2'd0, 8'h30), 1'b0);   // R4 R5 indirect jump
    run(mk(2'b00, 2'd1, 1'b0, 2'd3, 8'h05), 1'b0);   // R6 JSR AC3-relative
    run(mk(2'b00, 2'd0, 1'b0, 2'd1, 8'hfe), 1'b0);   // R3 PC-relative back
    run(16'h8123, 1'b0);                               // R2 arithmetic encoding
    run(16'h7abc, 1'b0);                               // R2 augmented class
    run(mk(2'b01, 2'd1, 1'b1, 2'd1, 8'h7f), 1'b1);   // R10 restart while busy

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      int sel;
      sel = int'($urandom % 16);
      w = 16'($urandom);
      if (sel == 0) begin
        w[15] = 1'b1;
      end else if (sel == 1) begin
        w[15] = 1'b0; w[14:13] = 2'b11;
      end else begin
        w[15] = 1'b0;
        w[14:13] = 2'($urandom % 3);
      end
      run(w, ($urandom % 8) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule